// File: doc/BRIEF.md
# Same-Bank Refresh Timing Checker

This block sits beside a DRAM command scheduler and answers one question: given a candidate command, a rank and a bank, what is the earliest clock cycle at which that command may go out without breaking a same-bank timing rule? It keeps a timestamp history of the last issue of each command type. The history is organised by "slot" rather than by physical bank. A slot groups together the banks that share one bank position across all bank groups of a rank. A same-bank precharge or same-bank refresh acts on a whole slot at once.

The scheduler presents a query every cycle on the query port and reads the answer one clock later. When it actually issues a command, it raises the issue strobe. The block then records the current cycle against that command and slot. In the same cycle it produces a broadcast mask of the banks on the rank that a slot-wide command touches, so that the per-bank state machines can all be updated together. All timing values are static inputs counted in clock cycles. Timestamps come from an internal free-running cycle counter, and that counter is also exported so that the scheduler shares the same time base.

Top module: `srt_same_bank_timer`

## Requirements
- R1: While reset is asserted, `q_earliest` and `cur_cycle` are 0. After reset no history is valid, so every query returns the cycle in which it was presented.
- R2: The slot of a (rank, bank) pair is rank × BANKS_PER_GROUP + (bank mod BANKS_PER_GROUP). History written through one bank constrains queries for every bank of the same slot. It has no effect on another slot or another rank.
- R3: A same-bank precharge query (code 6) returns no less than the slot's last activate (code 0) + t_ras + 1, and no less than the slot's last read (code 1) or read-with-autoprecharge (code 2) + t_rtp + 1.
- R4: A same-bank precharge query returns no less than the slot's last write (code 3) or write-with-autoprecharge (code 4) + t_wrpre + 1.
- R5: A same-bank refresh query (code 7) returns no less than the slot's last activate + t_rc + 1, last read-with-autoprecharge + t_rdaact + 1, and last write-with-autoprecharge + t_wraact + 1.
- R6: A same-bank refresh query returns no less than the slot's last precharge (code 5) or last same-bank precharge + t_rp, with no extra cycle.
- R7: An activate query returns no less than the slot's last same-bank precharge + t_rp − cmd_offset, and no less than the slot's last same-bank refresh + t_rfcsb − cmd_offset.
- R8: The answer is the maximum of the query cycle and all terms whose history entry has been written. An entry that was never written adds no term. Read and write queries (codes 1–4) and precharge queries (code 5) have no rules here and return the query cycle.
- R9: While `iss_valid` is high with a same-bank precharge or refresh, `bcast_mask` has bit b set exactly for the banks b with b mod BANKS_PER_GROUP = iss_bank mod BANKS_PER_GROUP, which is NUM_GROUPS bits. Otherwise the mask is 0.
- R10: A new issue of the same command to the same slot replaces the stored timestamp, so only the most recent issue constrains later queries.
- R11: `q_earliest` is registered and shows the answer for the query held in the previous cycle. `cur_cycle` rises by one every clock after reset, and an issue records the `cur_cycle` value of its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_ras | input | TW | Activate to precharge, cycles |
| t_rtp | input | TW | Read to precharge, cycles |
| t_wrpre | input | TW | Write to precharge, cycles |
| t_rc | input | TW | Activate to activate/refresh, cycles |
| t_rdaact | input | TW | Read-with-autoprecharge to activate, cycles |
| t_wraact | input | TW | Write-with-autoprecharge to activate, cycles |
| t_rp | input | TW | Precharge period, cycles |
| t_rfcsb | input | TW | Same-bank refresh period, cycles |
| cmd_offset | input | TW | Command offset subtracted from activate rules |
| q_cmd | input | 3 | Queried command code |
| q_rank | input | RANK_W | Queried rank |
| q_bank | input | BANK_W | Queried bank within rank |
| q_earliest | output | TS_W | Earliest legal cycle, registered |
| iss_valid | input | 1 | Issue strobe |
| iss_cmd | input | 3 | Issued command code |
| iss_rank | input | RANK_W | Issued rank |
| iss_bank | input | BANK_W | Issued bank within rank |
| bcast_mask | output | BANKS_PER_RANK | Banks touched by a slot-wide command |
| cur_cycle | output | TS_W | Free-running cycle count |

## Verification
A stale or misplaced history entry shows up as a wrong `q_earliest` on the first query for the affected slot, one clock after that query is presented. Such an entry is a timestamp filed under the wrong slot, a valid bit left set across reset, or a term added with a missing or extra cycle. The error appears as an answer that is too early or too late by exactly the broken amount. The bench therefore queries through sibling banks of a slot, through other slots and through the other rank, and it compares the result with its own model of the rules. A wrong slot decode in the broadcast logic shows as a wrong bit pattern on `bcast_mask` in the very cycle of the issue.

// File: rtl/srt_pkg.sv
package srt_pkg;

  localparam int CMD_W    = 3;
  localparam int NUM_CMDS = 8;

  typedef enum logic [CMD_W-1:0] {
    CMD_ACT   = 3'd0,
    CMD_RD    = 3'd1,
    CMD_RDA   = 3'd2,
    CMD_WR    = 3'd3,
    CMD_WRA   = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_PRESB = 3'd6,
    CMD_REFSB = 3'd7
  } srt_cmd_e;

  function automatic logic is_slot_cmd(input logic [CMD_W-1:0] c);
    return (c == CMD_PRESB) || (c == CMD_REFSB);
  endfunction

endpackage

// File: rtl/srt_cycle_counter.sv
module srt_cycle_counter #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] count
);

  logic [TS_W-1:0] cnt_d;
  logic [TS_W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/srt_history.sv
module srt_history
  import srt_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3,
  parameter int TS_W      = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [CMD_W-1:0]               wr_cmd,
  input  logic [SLOT_W-1:0]              wr_slot,
  input  logic [TS_W-1:0]                wr_time,
  input  logic [SLOT_W-1:0]              rd_slot,
  output logic [NUM_CMDS-1:0][TS_W-1:0]  rd_ts,
  output logic [NUM_CMDS-1:0]            rd_vld
);

  logic [TS_W-1:0] ts_q  [NUM_CMDS][NUM_SLOTS];
  logic            vld_q [NUM_CMDS][NUM_SLOTS];

  for (genvar c = 0; c < NUM_CMDS; c++) begin : g_cmd
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_cmd == CMD_W'(c)) && (wr_slot == SLOT_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   vld_q[c][s] <= 1'b0;
        else if (hit) vld_q[c][s] <= 1'b1;
      end

      always_ff @(posedge clk) begin
        if (hit) ts_q[c][s] <= wr_time;
      end
    end

    assign rd_ts[c]  = ts_q[c][rd_slot];
    assign rd_vld[c] = vld_q[c][rd_slot];
  end

endmodule

// File: rtl/srt_bcast_mask.sv
module srt_bcast_mask #(
  parameter int BANKS_PER_RANK  = 16,
  parameter int BANKS_PER_GROUP = 4,
  parameter int BANK_W          = 4
) (
  input  logic                      iss_valid,
  input  logic                      iss_slot_cmd,
  input  logic [BANK_W-1:0]         iss_bank,
  output logic [BANKS_PER_RANK-1:0] mask
);

  int pos;
  assign pos = int'(iss_bank) % BANKS_PER_GROUP;

  for (genvar b = 0; b < BANKS_PER_RANK; b++) begin : g_bank
    assign mask[b] = iss_valid && iss_slot_cmd && (pos == (b % BANKS_PER_GROUP));
  end

endmodule

// File: rtl/srt_limit_calc.sv
module srt_limit_calc
  import srt_pkg::*;
#(
  parameter int TS_W = 32,
  parameter int TW   = 8
) (
  input  logic [CMD_W-1:0]              q_cmd,
  input  logic [TS_W-1:0]               now,
  input  logic [NUM_CMDS-1:0][TS_W-1:0] hist_ts,
  input  logic [NUM_CMDS-1:0]           hist_vld,
  input  logic [TW-1:0]                 t_ras,
  input  logic [TW-1:0]                 t_rtp,
  input  logic [TW-1:0]                 t_wrpre,
  input  logic [TW-1:0]                 t_rc,
  input  logic [TW-1:0]                 t_rdaact,
  input  logic [TW-1:0]                 t_wraact,
  input  logic [TW-1:0]                 t_rp,
  input  logic [TW-1:0]                 t_rfcsb,
  input  logic [TW-1:0]                 cmd_offset,
  output logic [TS_W-1:0]               earliest
);

  localparam int WW = TS_W + 1;

  logic [NUM_CMDS-1:0][TW-1:0]   gap;
  logic [NUM_CMDS-1:0]           use_term;
  logic [NUM_CMDS-1:0]           plus_one;
  logic [NUM_CMDS-1:0]           less_off;
  logic [NUM_CMDS-1:0][TS_W-1:0] term;

  // Rule selection: which history source constrains the queried command.
  always_comb begin
    gap      = '0;
    use_term = '0;
    plus_one = '0;
    less_off = '0;
    unique case (srt_cmd_e'(q_cmd))
      CMD_PRESB: begin
        use_term[CMD_ACT] = 1'b1; gap[CMD_ACT] = t_ras;   plus_one[CMD_ACT] = 1'b1;
        use_term[CMD_RD]  = 1'b1; gap[CMD_RD]  = t_rtp;   plus_one[CMD_RD]  = 1'b1;
        use_term[CMD_RDA] = 1'b1; gap[CMD_RDA] = t_rtp;   plus_one[CMD_RDA] = 1'b1;
        use_term[CMD_WR]  = 1'b1; gap[CMD_WR]  = t_wrpre; plus_one[CMD_WR]  = 1'b1;
        use_term[CMD_WRA] = 1'b1; gap[CMD_WRA] = t_wrpre; plus_one[CMD_WRA] = 1'b1;
      end
      CMD_REFSB: begin
        use_term[CMD_ACT]   = 1'b1; gap[CMD_ACT]   = t_rc;     plus_one[CMD_ACT] = 1'b1;
        use_term[CMD_RDA]   = 1'b1; gap[CMD_RDA]   = t_rdaact; plus_one[CMD_RDA] = 1'b1;
        use_term[CMD_WRA]   = 1'b1; gap[CMD_WRA]   = t_wraact; plus_one[CMD_WRA] = 1'b1;
        use_term[CMD_PRE]   = 1'b1; gap[CMD_PRE]   = t_rp;
        use_term[CMD_PRESB] = 1'b1; gap[CMD_PRESB] = t_rp;
      end
      CMD_ACT: begin
        use_term[CMD_PRESB] = 1'b1; gap[CMD_PRESB] = t_rp;    less_off[CMD_PRESB] = 1'b1;
        use_term[CMD_REFSB] = 1'b1; gap[CMD_REFSB] = t_rfcsb; less_off[CMD_REFSB] = 1'b1;
      end
      default: ;
    endcase
  end

  // One candidate cycle per history source, clamped at zero.
  for (genvar c = 0; c < NUM_CMDS; c++) begin : g_term
    logic [WW-1:0] raw;
    logic [WW-1:0] off;
    assign raw     = {1'b0, hist_ts[c]} + WW'(gap[c]) + WW'(plus_one[c]);
    assign off     = less_off[c] ? WW'(cmd_offset) : '0;
    assign term[c] = (raw > off) ? TS_W'(raw - off) : '0;
  end

  // Maximum over the query cycle and all valid, selected terms.
  always_comb begin
    earliest = now;
    for (int c = 0; c < NUM_CMDS; c++) begin
      if (use_term[c] && hist_vld[c] && (term[c] > earliest)) earliest = term[c];
    end
  end

endmodule

// File: rtl/srt_same_bank_timer.sv
module srt_same_bank_timer
  import srt_pkg::*;
#(
  parameter  int NUM_RANKS       = 2,
  parameter  int BANKS_PER_GROUP = 4,
  parameter  int NUM_GROUPS      = 4,
  parameter  int TS_W            = 32,
  parameter  int TW              = 8,
  localparam int BANKS_PER_RANK  = BANKS_PER_GROUP * NUM_GROUPS,
  localparam int RANK_W          = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W          = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [TW-1:0]             t_ras,
  input  logic [TW-1:0]             t_rtp,
  input  logic [TW-1:0]             t_wrpre,
  input  logic [TW-1:0]             t_rc,
  input  logic [TW-1:0]             t_rdaact,
  input  logic [TW-1:0]             t_wraact,
  input  logic [TW-1:0]             t_rp,
  input  logic [TW-1:0]             t_rfcsb,
  input  logic [TW-1:0]             cmd_offset,
  input  logic [CMD_W-1:0]          q_cmd,
  input  logic [RANK_W-1:0]         q_rank,
  input  logic [BANK_W-1:0]         q_bank,
  output logic [TS_W-1:0]           q_earliest,
  input  logic                      iss_valid,
  input  logic [CMD_W-1:0]          iss_cmd,
  input  logic [RANK_W-1:0]         iss_rank,
  input  logic [BANK_W-1:0]         iss_bank,
  output logic [BANKS_PER_RANK-1:0] bcast_mask,
  output logic [TS_W-1:0]           cur_cycle
);

  localparam int NUM_SLOTS = NUM_RANKS * BANKS_PER_GROUP;
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [SLOT_W-1:0]              q_slot;
  logic [SLOT_W-1:0]              iss_slot;
  logic [NUM_CMDS-1:0][TS_W-1:0]  hist_ts;
  logic [NUM_CMDS-1:0]            hist_vld;
  logic [TS_W-1:0]                limit_d;
  logic [TS_W-1:0]                limit_q;

  assign q_slot   = SLOT_W'(int'(q_rank) * BANKS_PER_GROUP + int'(q_bank) % BANKS_PER_GROUP);
  assign iss_slot = SLOT_W'(int'(iss_rank) * BANKS_PER_GROUP + int'(iss_bank) % BANKS_PER_GROUP);

  srt_cycle_counter #(.TS_W(TS_W)) u_cycle (
    .clk   (clk),
    .rst_n (rst_n),
    .count (cur_cycle)
  );

  srt_history #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .TS_W      (TS_W)
  ) u_history (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (iss_valid),
    .wr_cmd  (iss_cmd),
    .wr_slot (iss_slot),
    .wr_time (cur_cycle),
    .rd_slot (q_slot),
    .rd_ts   (hist_ts),
    .rd_vld  (hist_vld)
  );

  srt_limit_calc #(.TS_W(TS_W), .TW(TW)) u_limit (
    .q_cmd      (q_cmd),
    .now        (cur_cycle),
    .hist_ts    (hist_ts),
    .hist_vld   (hist_vld),
    .t_ras      (t_ras),
    .t_rtp      (t_rtp),
    .t_wrpre    (t_wrpre),
    .t_rc       (t_rc),
    .t_rdaact   (t_rdaact),
    .t_wraact   (t_wraact),
    .t_rp       (t_rp),
    .t_rfcsb    (t_rfcsb),
    .cmd_offset (cmd_offset),
    .earliest   (limit_d)
  );

  srt_bcast_mask #(
    .BANKS_PER_RANK  (BANKS_PER_RANK),
    .BANKS_PER_GROUP (BANKS_PER_GROUP),
    .BANK_W          (BANK_W)
  ) u_mask (
    .iss_valid    (iss_valid),
    .iss_slot_cmd (is_slot_cmd(iss_cmd)),
    .iss_bank     (iss_bank),
    .mask         (bcast_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) limit_q <= '0;
    else        limit_q <= limit_d;
  end

  assign q_earliest = limit_q;

endmodule

// File: rtl/srt_checker.sv
module srt_checker
  import srt_pkg::*;
#(
  parameter int TS_W           = 32,
  parameter int BANK_W         = 4,
  parameter int BANKS_PER_RANK = 16,
  parameter int NUM_GROUPS     = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      iss_valid,
  input logic [CMD_W-1:0]          iss_cmd,
  input logic [BANK_W-1:0]         iss_bank,
  input logic [BANKS_PER_RANK-1:0] bcast_mask,
  input logic [TS_W-1:0]           q_earliest,
  input logic [TS_W-1:0]           cur_cycle
);

  logic slot_issue;
  assign slot_issue = iss_valid && ((iss_cmd == CMD_PRESB) || (iss_cmd == CMD_REFSB));

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (q_earliest == '0 && cur_cycle == '0));

  p_mask_own_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_issue |-> bcast_mask[iss_bank]);

  p_mask_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_issue |-> ($countones(bcast_mask) == NUM_GROUPS));

  p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_issue |-> (bcast_mask == '0));

  p_not_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_earliest >= $past(cur_cycle)));

  p_cycle_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cur_cycle == $past(cur_cycle) + TS_W'(1)));

endmodule

bind srt_same_bank_timer srt_checker #(
  .TS_W           (TS_W),
  .BANK_W         (BANK_W),
  .BANKS_PER_RANK (BANKS_PER_RANK),
  .NUM_GROUPS     (NUM_GROUPS)
) u_srt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_cmd    (iss_cmd),
  .iss_bank   (iss_bank),
  .bcast_mask (bcast_mask),
  .q_earliest (q_earliest),
  .cur_cycle  (cur_cycle)
);

// File: tb/srt_same_bank_timer_tb_top.sv
module srt_same_bank_timer_tb_top;

  localparam int CLK_P = 10;
  localparam int BPG   = 4;
  localparam int BPR   = 16;

  localparam int T_RAS = 20, T_RTP = 5,  T_WRPRE = 30, T_RC = 40, T_RDAACT = 25;
  localparam int T_WRAACT = 45, T_RP = 12, T_RFCSB = 60, T_OFF = 3;

  localparam logic [2:0] C_ACT = 3'd0, C_RD = 3'd1, C_RDA = 3'd2, C_WR = 3'd3;
  localparam logic [2:0] C_WRA = 3'd4, C_PRE = 3'd5, C_PRESB = 3'd6, C_REFSB = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  q_cmd, iss_cmd;
  logic        q_rank, iss_rank, iss_valid;
  logic [3:0]  q_bank, iss_bank;
  logic [31:0] q_earliest, cur_cycle;
  logic [15:0] bcast_mask;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  longint hts [8][8];
  bit     hv  [8][8];

  always #(CLK_P/2) clk = ~clk;

  srt_same_bank_timer dut_i (
    .clk(clk), .rst_n(rst_n),
    .t_ras(8'(T_RAS)), .t_rtp(8'(T_RTP)), .t_wrpre(8'(T_WRPRE)), .t_rc(8'(T_RC)),
    .t_rdaact(8'(T_RDAACT)), .t_wraact(8'(T_WRAACT)), .t_rp(8'(T_RP)),
    .t_rfcsb(8'(T_RFCSB)), .cmd_offset(8'(T_OFF)),
    .q_cmd(q_cmd), .q_rank(q_rank), .q_bank(q_bank), .q_earliest(q_earliest),
    .iss_valid(iss_valid), .iss_cmd(iss_cmd), .iss_rank(iss_rank), .iss_bank(iss_bank),
    .bcast_mask(bcast_mask), .cur_cycle(cur_cycle)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int slot_of(input int rank, input int bank);
    return rank * BPG + bank % BPG;
  endfunction

  function automatic longint model(input int cmd, input int rank, input int bank, input longint n);
    int s = slot_of(rank, bank);
    longint best = n;
    longint t;
    int src[5]; int gap[5]; int cnt = 0;
    if (cmd == 6) begin
      src = '{0, 1, 2, 3, 4}; gap = '{T_RAS+1, T_RTP+1, T_RTP+1, T_WRPRE+1, T_WRPRE+1}; cnt = 5;
    end else if (cmd == 7) begin
      src = '{0, 2, 4, 5, 6}; gap = '{T_RC+1, T_RDAACT+1, T_WRAACT+1, T_RP, T_RP}; cnt = 5;
    end else if (cmd == 0) begin
      src = '{6, 7, 0, 0, 0}; gap = '{T_RP-T_OFF, T_RFCSB-T_OFF, 0, 0, 0}; cnt = 2;
    end
    for (int i = 0; i < cnt; i++) begin
      if (hv[src[i]][s]) begin
        t = hts[src[i]][s] + gap[i];
        if (t > best) best = t;
      end
    end
    return best;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; iss_valid = 1'b0; iss_cmd = 3'd0; iss_rank = 1'b0; iss_bank = 4'd0;
    q_cmd = C_RD; q_rank = 1'b0; q_bank = 4'd0;
    for (int c = 0; c < 8; c++) for (int s = 0; s < 8; s++) hv[c][s] = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic issue(input logic [2:0] cmd, input int rank, input int bank,
                       output logic [15:0] mask, output longint ts);
    @(negedge clk);
    iss_valid = 1'b1; iss_cmd = cmd; iss_rank = 1'(rank); iss_bank = 4'(bank);
    ts = longint'(cur_cycle);
    #1 mask = bcast_mask;
    hts[cmd][slot_of(rank, bank)] = ts;
    hv[cmd][slot_of(rank, bank)]  = 1'b1;
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  task automatic iss(input logic [2:0] cmd, input int rank, input int bank);
    logic [15:0] m; longint ts;
    issue(cmd, rank, bank, m, ts);
  endtask

  task automatic query(input logic [2:0] cmd, input int rank, input int bank,
                       output longint res, output longint n);
    @(negedge clk);
    q_cmd = cmd; q_rank = 1'(rank); q_bank = 4'(bank);
    n = longint'(cur_cycle);
    @(posedge clk);
    #1 res = longint'(q_earliest);
  endtask

  task automatic qcheck(input string req, input logic [2:0] cmd, input int rank, input int bank);
    longint r, n;
    query(cmd, rank, bank, r, n);
    check(req, r, model(int'(cmd), rank, bank, n));
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
  endtask

  // R1: reset values and empty history
  task automatic t_reset();
    longint r, n;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 q_earliest in reset", longint'(q_earliest), 0);
    check("R1 cur_cycle in reset", longint'(cur_cycle), 0);
    do_reset();
    query(C_PRESB, 0, 0, r, n);
    check("R1 empty history", r, n);
  endtask

  // R3: precharge after activate and reads
  task automatic t_presb_act_rd();
    longint r, n, a, d; logic [15:0] m;
    do_reset();
    issue(C_ACT, 0, 1, m, a);
    iss(C_RD, 0, 5);
    query(C_PRESB, 0, 9, r, n);
    check("R3 activate term", r, a + T_RAS + 1);
    idle(20);
    issue(C_RDA, 0, 13, m, d);
    query(C_PRESB, 0, 1, r, n);
    check("R3 read-ap term", r, d + T_RTP + 1);
  endtask

  // R4: precharge after writes
  task automatic t_presb_wr();
    do_reset();
    iss(C_WR, 1, 2);
    qcheck("R4 write term", C_PRESB, 1, 14);
    idle(8);
    iss(C_WRA, 1, 6);
    qcheck("R4 write-ap term", C_PRESB, 1, 2);
  endtask

  // R5: refresh after activate / autoprecharge
  task automatic t_refsb_act();
    longint r, n, a; logic [15:0] m;
    do_reset();
    issue(C_ACT, 0, 0, m, a);
    query(C_REFSB, 0, 12, r, n);
    check("R5 activate term", r, a + T_RC + 1);
    idle(30);
    iss(C_RDA, 0, 4);
    qcheck("R5 read-ap term", C_REFSB, 0, 8);
    iss(C_WRA, 0, 8);
    qcheck("R5 write-ap term from slot sibling", C_REFSB, 0, 0);
  endtask

  // R6: refresh after precharges, no extra cycle
  task automatic t_refsb_pre();
    longint r, n, p; logic [15:0] m;
    do_reset();
    issue(C_PRE, 1, 3, m, p);
    query(C_REFSB, 1, 7, r, n);
    check("R6 precharge term", r, p + T_RP);
    idle(5);
    issue(C_PRESB, 1, 11, m, p);
    query(C_REFSB, 1, 15, r, n);
    check("R6 slot precharge term", r, p + T_RP);
  endtask

  // R7: activate after slot precharge / slot refresh
  task automatic t_act_rules();
    longint r, n, s; logic [15:0] m;
    do_reset();
    issue(C_PRESB, 0, 2, m, s);
    query(C_ACT, 0, 6, r, n);
    check("R7 slot precharge minus offset", r, s + T_RP - T_OFF);
    issue(C_REFSB, 0, 10, m, s);
    query(C_ACT, 0, 14, r, n);
    check("R7 slot refresh minus offset", r, s + T_RFCSB - T_OFF);
  endtask

  // R2: slot isolation across slots and ranks
  task automatic t_isolation();
    longint r, n, a; logic [15:0] m;
    do_reset();
    issue(C_ACT, 1, 1, m, a);
    iss(C_ACT, 0, 2);
    query(C_PRESB, 0, 1, r, n);
    check("R2 other rank/slot ignored", r, n);
    query(C_PRESB, 1, 5, r, n);
    check("R2 same slot other bank", r, a + T_RAS + 1);
  endtask

  // R8: commands without rules, expired constraints
  task automatic t_no_rule();
    longint r, n;
    do_reset();
    iss(C_ACT, 0, 1);
    iss(C_PRESB, 0, 1);
    query(C_RD, 0, 1, r, n);
    check("R8 read query unconstrained", r, n);
    query(C_PRE, 0, 5, r, n);
    check("R8 precharge query unconstrained", r, n);
    idle(50);
    query(C_PRESB, 0, 1, r, n);
    check("R8 expired terms give query cycle", r, n);
  endtask

  // R9: broadcast mask
  task automatic t_mask();
    logic [15:0] m; longint ts;
    do_reset();
    issue(C_PRESB, 0, 6, m, ts);
    check("R9 mask slot precharge bank 6", longint'(m), 64'h4444);
    issue(C_REFSB, 1, 3, m, ts);
    check("R9 mask slot refresh bank 3", longint'(m), 64'h8888);
    issue(C_ACT, 0, 6, m, ts);
    check("R9 mask zero for activate", longint'(m), 0);
    #1 check("R9 mask zero when idle", longint'(bcast_mask), 0);
  endtask

  // R10: latest issue replaces history
  task automatic t_overwrite();
    longint r, n, a; logic [15:0] m;
    do_reset();
    iss(C_ACT, 0, 3);
    idle(10);
    issue(C_ACT, 0, 7, m, a);
    query(C_PRESB, 0, 3, r, n);
    check("R10 newest activate", r, a + T_RAS + 1);
  endtask

  // R11: registered output and counter step
  task automatic t_timing();
    longint r, n, c0;
    do_reset();
    iss(C_ACT, 1, 0);
    query(C_PRESB, 1, 0, r, n);
    @(negedge clk);
    q_cmd = C_RD;
    c0 = longint'(cur_cycle);
    #1 check("R11 output held until edge", longint'(q_earliest), r);
    @(posedge clk); #1;
    check("R11 output updates after edge", longint'(q_earliest), c0);
    @(negedge clk);
    check("R11 counter steps by one", longint'(cur_cycle), c0 + 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; iss_cmd = 3'd0; iss_rank = 1'b0; iss_bank = 4'd0;
    q_cmd = C_RD; q_rank = 1'b0; q_bank = 4'd0;
    t_reset();
    t_presb_act_rd();
    t_presb_wr();
    t_refsb_act();
    t_refsb_pre();
    t_act_rules();
    t_isolation();
    t_no_rule();
    t_mask();
    t_overwrite();
    t_timing();
    finish_run();
  end

endmodule